// File: doc/BRIEF.md
# Memory Zero-Fill Engine

This block clears a region of physical memory on request from software. Software programs an inclusive start address and an inclusive end address through a 64-bit register port, then writes an opcode to the command register. The engine then issues zero-data write requests over the range, lowest address first. Each request covers at most one chunk of 4096 bytes. The final request is shortened so that no byte past the end address is written.

A busy output stays high for the whole of a fill. A level completion interrupt rises when a fill finishes, and also when a command is rejected. Two error outputs say why a command was rejected: the opcode was unknown, or the end address lies below the start address. The same register window also holds a sixteen-entry table and three scratch words. These only store and return what software writes to them.

The memory side is a simple request/acknowledge master. The engine holds address, length and first-beat byte enables steady until the memory acknowledges the request. The data of every write is zero.

Top module: `zf_engine`

## Requirements
- R1: After reset, busy, irq_done, err_op, err_range and mem_req are all 0, and every register reads as 0.
- R2: The start address at offset 0x3030 and the end address at offset 0x3038 read back the value written (low AW bits, zero-extended).
- R3: The table words at offsets 0x1700 + 8*k (k = 0..15) and the scratch words at 0x3008, 0x3018 and 0x4000 read back the value written. Writing them causes no memory request.
- R4: A write to offset 0x3800 with bits 7:0 equal to 0x11, while idle and with end >= start, raises busy on the next cycle. In that same cycle the engine presents its first request at the start address.
- R5: Requests are issued in ascending order. Each one starts where the previous one ended, and each carries a length of min(remaining, 4096) bytes, never 0.
- R6: The request lengths add up to end - start + 1. The last request ends exactly at the end address, so a range of one byte gives a single request of length 1.
- R7: Busy stays high until the final request is acknowledged. On that acknowledge, busy falls and irq_done rises. Any accepted command clears irq_done and both error flags.
- R8: A command write with any other opcode while idle makes no memory request. It sets err_op and irq_done on the next cycle.
- R9: A start command with end < start makes no memory request. It sets err_range and irq_done on the next cycle, and busy stays 0.
- R10: A command write while busy is ignored. The running fill continues unchanged and the error flags do not change.
- R11: mem_be holds the byte enables of the first 8-byte beat of a request. Bit i is 1 when byte lane i lies in the range from mem_addr[2:0] up to min(7, mem_addr[2:0] + mem_len - 1).
- R12: While mem_req is high and mem_ack is low, mem_addr, mem_len and mem_be stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| mem_req | output | 1 | Zero-write request valid |
| mem_addr | output | AW | Byte address of the request |
| mem_len | output | LENW | Byte count of the request |
| mem_be | output | 8 | Byte enables of the first beat |
| mem_ack | input | 1 | Request accepted and completed |
| busy | output | 1 | Fill in progress |
| irq_done | output | 1 | Completion interrupt, level |
| err_op | output | 1 | Last command had an unknown opcode |
| err_range | output | 1 | Last start command had end below start |

## Verification
Any fault in the running address or remaining-count registers shows up at the ports on the very next acknowledge. It appears as a request whose address does not follow on from the previous one, or whose length is wrong, or as a fill that ends early or late against end - start + 1. A wrong state bit shows at once: busy and mem_req disagree with the acknowledge history, or irq_done rises while requests are still outstanding. A fault in the command decode shows on the cycle after the command write. Either a request appears where none should, or an error flag is missing or changes while the engine is busy.

// File: rtl/zf_pkg.sv
package zf_pkg;
  localparam logic [15:0] OFF_START   = 16'h3030;
  localparam logic [15:0] OFF_END     = 16'h3038;
  localparam logic [15:0] OFF_CMD     = 16'h3800;
  localparam logic [15:0] OFF_TBL     = 16'h1700;
  localparam int          TBL_WORDS   = 16;
  localparam int          SCR_WORDS   = 3;
  localparam logic [15:0] OFF_SCR [SCR_WORDS] = '{16'h3008, 16'h3018, 16'h4000};
  localparam logic [7:0]  OP_ZERO     = 8'h11;

  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} zf_state_e;
endpackage

// File: rtl/zf_regs.sv
module zf_regs
  import zf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [15:0]   addr,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic          cmd_we,
  output logic [7:0]    cmd_op
);
  logic [63:0] tbl_q [TBL_WORDS];
  logic [63:0] scr_q [SCR_WORDS];
  logic [TBL_WORDS-1:0] tbl_hit;
  logic [SCR_WORDS-1:0] scr_hit;

  assign cmd_we = we && (addr == OFF_CMD);
  assign cmd_op = wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (we && addr == OFF_START) start_q <= wdata[AW-1:0];
      if (we && addr == OFF_END)   end_q   <= wdata[AW-1:0];
    end
  end

  for (genvar k = 0; k < TBL_WORDS; k++) begin : g_tbl
    assign tbl_hit[k] = (addr == OFF_TBL + 16'(8 * k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tbl_q[k] <= '0;
      else if (we && tbl_hit[k]) tbl_q[k] <= wdata;
    end
  end

  for (genvar s = 0; s < SCR_WORDS; s++) begin : g_scr
    assign scr_hit[s] = (addr == OFF_SCR[s]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                scr_q[s] <= '0;
      else if (we && scr_hit[s]) scr_q[s] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_START) rdata = 64'(start_q);
    if (addr == OFF_END)   rdata = 64'(end_q);
    for (int k = 0; k < TBL_WORDS; k++)
      if (tbl_hit[k]) rdata = tbl_q[k];
    for (int s = 0; s < SCR_WORDS; s++)
      if (scr_hit[s]) rdata = scr_q[s];
  end
endmodule

// File: rtl/zf_chunker.sv
module zf_chunker
  import zf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CHUNK = 4096,
  localparam int LENW = $clog2(CHUNK) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   first,
  input  logic [AW:0]     total,
  input  logic            mem_ack,
  output logic            busy,
  output logic            fin,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] mem_len,
  output logic [7:0]      mem_be
);
  zf_state_e      st_q, st_d;
  logic [AW-1:0]  cur_q, cur_d;
  logic [AW:0]    rem_q, rem_d;
  logic [LENW-1:0] chunk;
  logic [2:0]     lo, hi;
  logic [3:0]     span, last_lane;

  always_comb begin
    chunk = (rem_q > (AW+1)'(CHUNK)) ? LENW'(CHUNK) : rem_q[LENW-1:0];
  end

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    rem_d = rem_q;
    fin   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_FILL;
        cur_d = first;
        rem_d = total;
      end
      ST_FILL: if (mem_ack) begin
        cur_d = cur_q + AW'(chunk);
        rem_d = rem_q - (AW+1)'(chunk);
        if (rem_q == (AW+1)'(chunk)) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

  assign busy     = (st_q == ST_FILL);
  assign mem_req  = busy;
  assign mem_addr = cur_q;
  assign mem_len  = chunk;

  assign lo        = cur_q[2:0];
  assign span      = (chunk > LENW'(8)) ? 4'd8 : chunk[3:0];
  assign last_lane = {1'b0, lo} + span - 4'd1;
  assign hi        = (last_lane > 4'd7) ? 3'd7 : last_lane[2:0];

  for (genvar i = 0; i < 8; i++) begin : g_be
    assign mem_be[i] = busy && (3'(i) >= lo) && (3'(i) <= hi);
  end
endmodule

// File: rtl/zf_engine.sv
module zf_engine
  import zf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CHUNK = 4096,
  localparam int LENW = $clog2(CHUNK) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [15:0]     reg_addr,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] mem_len,
  output logic [7:0]      mem_be,
  input  logic            mem_ack,
  output logic            busy,
  output logic            irq_done,
  output logic            err_op,
  output logic            err_range
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [AW-1:0] first_q, last_q;
  logic          cmd_we, accept, bad_op, bad_rng, start, fin;
  logic [7:0]    cmd_op;
  logic [AW:0]   total;
  logic          done_d, eop_d, erng_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  zf_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .start_q(first_q), .end_q(last_q),
    .cmd_we(cmd_we), .cmd_op(cmd_op)
  );

  assign accept  = cmd_we && !busy;
  assign bad_op  = accept && (cmd_op != OP_ZERO);
  assign bad_rng = accept && (cmd_op == OP_ZERO) && (last_q < first_q);
  assign start   = accept && !bad_op && !bad_rng;
  assign total   = {1'b0, last_q} - {1'b0, first_q} + 1'b1;

  zf_chunker #(.AW(AW), .CHUNK(CHUNK)) u_chunk (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .first(first_q),
    .total(total), .mem_ack(mem_ack), .busy(busy), .fin(fin),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_be(mem_be)
  );

  always_comb begin
    done_d = irq_done;
    eop_d  = err_op;
    erng_d = err_range;
    if (accept) begin
      done_d = bad_op || bad_rng;
      eop_d  = bad_op;
      erng_d = bad_rng;
    end else if (fin) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_done  <= 1'b0;
      err_op    <= 1'b0;
      err_range <= 1'b0;
    end else begin
      irq_done  <= done_d;
      err_op    <= eop_d;
      err_range <= erng_d;
    end
  end
endmodule

// File: rtl/zf_engine_chk.sv
module zf_engine_chk
  import zf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CHUNK = 4096,
  localparam int LENW = $clog2(CHUNK) + 1
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            reg_we,
  input logic [15:0]     reg_addr,
  input logic [63:0]     reg_wdata,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr,
  input logic [LENW-1:0] mem_len,
  input logic [7:0]      mem_be,
  input logic            busy,
  input logic            irq_done,
  input logic            err_op,
  input logic            err_range,
  input logic [AW-1:0]   first_q,
  input logic [AW-1:0]   last_q
);
  logic cmd;
  assign cmd = reg_we && (reg_addr == OFF_CMD);

  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_be));

  a_r5_length_bounds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> (mem_len != '0) && (mem_len <= LENW'(CHUNK)));

  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + AW'($past(mem_len))));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_done |-> !busy && !mem_req);

  a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd && !busy && (reg_wdata[7:0] != OP_ZERO) |=> err_op && irq_done && !mem_req);

  a_r9_bad_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd && !busy && (reg_wdata[7:0] == OP_ZERO) && (last_q < first_q)
      |=> err_range && irq_done && !busy);

  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd && busy |=> $stable(err_op) && $stable(err_range));

  a_r11_be_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> mem_be != 8'h00);
endmodule

bind zf_engine zf_engine_chk #(.AW(AW), .CHUNK(CHUNK)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_be(mem_be), .busy(busy),
  .irq_done(irq_done), .err_op(err_op), .err_range(err_range),
  .first_q(first_q), .last_q(last_q)
);

// File: tb/tb_zf_engine.sv
module tb_zf_engine;
  localparam int AW = 32;
  localparam int LENW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0, busy, irq_done, err_op, err_range;
  logic [AW-1:0] mem_addr;
  logic [LENW-1:0] mem_len;
  logic [7:0] mem_be;

  int errors = 0, checks = 0;
  int ack_delay = 1;
  int nlog = 0;
  logic [AW-1:0] log_addr [16];
  logic [AW-1:0] log_seen [16];
  int            log_len  [16];
  logic [7:0]    log_be   [16];
  logic          log_busy [16];
  int req_cycles = 0;

  always #4 clk = ~clk;

  zf_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_be(mem_be), .mem_ack(mem_ack),
    .busy(busy), .irq_done(irq_done), .err_op(err_op), .err_range(err_range)
  );

  // memory responder
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_n = 0;
      end else if (mem_req) begin
        if (wait_n == 0 && nlog < 16) log_seen[nlog] = mem_addr;
        req_cycles++;
        if (wait_n >= ack_delay) begin
          if (nlog < 16) begin
            log_addr[nlog] = mem_addr;
            log_len[nlog]  = int'(mem_len);
            log_be[nlog]   = mem_be;
            log_busy[nlog] = busy;
          end
          nlog++;
          mem_ack = 1'b1;
        end else wait_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_be(input logic [AW-1:0] a, input int len);
    logic [7:0] b = '0;
    int lo = int'(a[2:0]);
    int hi = lo + len - 1;
    if (hi > 7) hi = 7;
    for (int i = 0; i < 8; i++) b[i] = (i >= lo && i <= hi);
    return b;
  endfunction

  // programs a range, starts, waits, and compares the request log
  task automatic run_fill(input logic [AW-1:0] f, input logic [AW-1:0] l, input string tag);
    longint rem;
    logic [AW-1:0] a;
    int n;
    nlog = 0;
    wr(16'h3030, 64'(f));
    wr(16'h3038, 64'(l));
    wr(16'h3800, 64'h11);
    chk(busy === 1'b1 && mem_req === 1'b1 && irq_done === 1'b0, {tag, " R4 busy/req after start"},
        {busy, mem_req, irq_done}, 3'b110);
    chk(mem_addr === f, {tag, " R4 first address"}, mem_addr, f);
    wait_idle();
    rem = longint'(l) - longint'(f) + 1;
    a = f;
    n = 0;
    while (rem > 0) begin
      int len = (rem > 4096) ? 4096 : int'(rem);
      if (n < 16) begin
        chk(log_addr[n] === a, {tag, " R5 chunk address"}, log_addr[n], a);
        chk(log_len[n] == len, {tag, " R5/R6 chunk length"}, log_len[n], len);
        chk(log_be[n] === exp_be(a, len), {tag, " R11 byte enables"}, log_be[n], exp_be(a, len));
        chk(log_busy[n] === 1'b1, {tag, " R7 busy until final ack"}, log_busy[n], 1);
        chk(log_seen[n] === log_addr[n], {tag, " R12 address held"}, log_seen[n], log_addr[n]);
      end
      a = a + AW'(len);
      rem -= len;
      n++;
    end
    chk(nlog == n, {tag, " R6 chunk count"}, nlog, n);
    chk(busy === 1'b0 && irq_done === 1'b1 && err_op === 1'b0 && err_range === 1'b0,
        {tag, " R7 completion flags"}, {busy, irq_done, err_op, err_range}, 4'b0100);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk(busy === 1'b0 && irq_done === 1'b0 && err_op === 1'b0 && err_range === 1'b0 && mem_req === 1'b0,
        "R1 outputs after reset", {busy, irq_done, err_op, err_range, mem_req}, 0);
    rd(16'h3030, d); chk(d === 64'h0, "R1 start reg reset", d, 0);
    rd(16'h1708, d); chk(d === 64'h0, "R1 table reset", d, 0);
  endtask

  task automatic t_regs();
    logic [63:0] d;
    logic [15:0] scr [3] = '{16'h3008, 16'h3018, 16'h4000};
    req_cycles = 0;
    wr(16'h3030, 64'hDEAD_BEEF);
    wr(16'h3038, 64'h1234_5678);
    rd(16'h3030, d); chk(d === 64'hDEAD_BEEF, "R2 start readback", d, 64'hDEAD_BEEF);
    rd(16'h3038, d); chk(d === 64'h1234_5678, "R2 end readback", d, 64'h1234_5678);
    for (int k = 0; k < 16; k++) wr(16'h1700 + 16'(8 * k), 64'hA5A5_0000_0000_0000 + 64'(k * 3 + 1));
    for (int s = 0; s < 3; s++) wr(scr[s], 64'hC0DE_0000_0000_0000 + 64'(s));
    for (int k = 0; k < 16; k++) begin
      rd(16'h1700 + 16'(8 * k), d);
      chk(d === 64'hA5A5_0000_0000_0000 + 64'(k * 3 + 1), "R3 table readback", d,
          64'hA5A5_0000_0000_0000 + 64'(k * 3 + 1));
    end
    for (int s = 0; s < 3; s++) begin
      rd(scr[s], d);
      chk(d === 64'hC0DE_0000_0000_0000 + 64'(s), "R3 scratch readback", d, 64'hC0DE_0000_0000_0000 + 64'(s));
    end
    chk(req_cycles == 0 && busy === 1'b0, "R3 no memory request", req_cycles, 0);
  endtask

  task automatic t_badop();
    nlog = 0; req_cycles = 0;
    wr(16'h3800, 64'h22);
    chk(err_op === 1'b1 && irq_done === 1'b1 && busy === 1'b0, "R8 unknown opcode flags",
        {err_op, irq_done, busy}, 3'b110);
    repeat (4) @(negedge clk);
    chk(req_cycles == 0, "R8 no memory request", req_cycles, 0);
  endtask

  task automatic t_range();
    nlog = 0; req_cycles = 0;
    wr(16'h3030, 64'h9000);
    wr(16'h3038, 64'h8FFF);
    wr(16'h3800, 64'h11);
    chk(err_range === 1'b1 && irq_done === 1'b1 && busy === 1'b0 && err_op === 1'b0,
        "R9 range error flags", {err_range, irq_done, busy, err_op}, 4'b1100);
    repeat (4) @(negedge clk);
    chk(req_cycles == 0, "R9 no memory request", req_cycles, 0);
  endtask

  task automatic t_busy_ignore();
    nlog = 0;
    ack_delay = 6;
    wr(16'h3030, 64'h0);
    wr(16'h3038, 64'h1FFF);
    wr(16'h3800, 64'h11);
    wr(16'h3800, 64'h33);
    chk(err_op === 1'b0 && busy === 1'b1, "R10 bad opcode ignored while busy", {err_op, busy}, 2'b01);
    wr(16'h3030, 64'h8000);
    wr(16'h3800, 64'h11);
    wait_idle();
    chk(nlog == 2, "R10 chunk count unchanged", nlog, 2);
    chk(log_addr[0] === 32'h0 && log_addr[1] === 32'h1000, "R10 addresses unchanged",
        {log_addr[0], log_addr[1]}, 64'h0000_0000_0000_1000);
    chk(err_op === 1'b0 && err_range === 1'b0 && irq_done === 1'b1, "R10 flags after fill",
        {err_op, err_range, irq_done}, 3'b001);
    ack_delay = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    run_fill(32'h1000, 32'h3FFF, "aligned");
    run_fill(32'h2003, 32'h3005, "unaligned");
    run_fill(32'h0505, 32'h0505, "single");
    t_badop();
    ack_delay = 0;
    run_fill(32'h7FF9, 32'h8002, "fast-ack");
    ack_delay = 1;
    t_range();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule